// File: doc/BRIEF.md
# SMRAM Control and Access Router

This block holds the 8-bit control register for the system-management RAM window of a host bridge. It also makes the routing decision for every access that lands in that window. Software writes the register through the configuration path. For each access, the requester supplies two flags: whether the CPU is in system-management mode, and whether the access is an instruction fetch or a data reference. From these the block decides, combinationally, whether the access is served by DRAM or passed on to the bus.

The register has a lock bit. Once the lock bit is set, the open bit can no longer be set and the lock itself stays set. Only a power-on reset (the block's synchronous reset) clears it. The block flags the case where the open and closed bits are both stored as 1. While that flag is raised, every access is sent to the bus. Decoding the base segment into an address window is outside this block, and so is the memory datapath.

Top module: `smram_access_router`

## Requirements
- R1: After reset the register reads 0x02, and with it the route is bus, the illegal flag is low and smram_enabled is low.
- R2: Register bits: bit 6 open, bit 5 closed, bit 4 lock, bit 3 enable, bit 7 reserved, bits 2:0 base segment. A write stores (data AND 0x78) OR 0x02, so bit 7 reads 0 and bits 2:0 read 010.
- R3: While the stored lock bit is 1, every write stores bit 6 as 0 and bit 4 as 1. Only reset clears the lock bit.
- R4: With the enable bit at 0, every access is routed to the bus (route_dram = 0), whatever the access flags are.
- R5: With enable at 1, lock at 0, open at 1 and closed at 0, every access goes to DRAM (route_dram = 1), in or out of SMM.
- R6: With enable at 1, lock at 0 and open at 0, an access outside SMM goes to the bus.
- R7: With enable at 1 and closed at 0, an access in SMM goes to DRAM, for both code and data.
- R8: With enable at 1, closed at 1 and open at 0, an access in SMM goes to DRAM when it is a code fetch and to the bus when it is a data access.
- R9: With enable at 1 and lock at 1, an access outside SMM goes to the bus, whatever the open bit is.
- R10: While the stored open and closed bits are both 1, illegal_state is 1 and every access is routed to the bus. Otherwise illegal_state is 0.
- R11: smram_enabled always equals the stored enable bit (bit 3).
- R12: In a cycle with no write, the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| acc_in_smm | input | 1 | Current access is made in system-management mode |
| acc_is_code | input | 1 | Current access is an instruction fetch (0 = data) |
| ctrl_value | output | 8 | Stored control register value |
| route_dram | output | 1 | 1 = route access to DRAM, 0 = route to bus |
| illegal_state | output | 1 | Open and closed are both stored as 1 |
| smram_enabled | output | 1 | Stored enable bit |

## Verification
The bench builds the block with the default base-segment parameter of 010, which is the value the requirements fix for bits 2:0. With that one setting, every register image can be reached: unlocked, locked with open still set from the locking write, locked and closed, and the illegal open-plus-closed pair. For each image, all four combinations of SMM and code/data flags are applied. A reset in the middle of the run confirms that the lock clears only through reset. A stretch of pseudo-random writes and accesses follows.

// File: rtl/smram_pkg.sv
package smram_pkg;

    typedef struct packed {
        logic       rsvd;
        logic       open_b;
        logic       closed_b;
        logic       lock_b;
        logic       enable_b;
        logic [2:0] seg;
    } smram_ctrl_t;

    typedef enum logic {
        ROUTE_BUS  = 1'b0,
        ROUTE_DRAM = 1'b1
    } route_e;

    // Value stored by a write, given the current register contents.
    function automatic smram_ctrl_t next_ctrl(smram_ctrl_t cur, logic [7:0] d, logic [2:0] seg_const);
        smram_ctrl_t n;
        n      = smram_ctrl_t'(d);
        n.rsvd = 1'b0;
        n.seg  = seg_const;
        if (cur.lock_b) begin
            n.open_b = 1'b0;
            n.lock_b = 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/smram_ctrl_reg.sv
module smram_ctrl_reg
    import smram_pkg::*;
#(
    parameter logic [2:0] SEG_CONST = 3'b010
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output smram_ctrl_t ctrl_q
);
    localparam smram_ctrl_t RESET_VAL = smram_ctrl_t'({5'b00000, SEG_CONST});

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= RESET_VAL;
        end else if (wr_en) begin
            ctrl_q <= next_ctrl(ctrl_q, wr_data, SEG_CONST);
        end
    end
endmodule

// File: rtl/smram_router.sv
module smram_router
    import smram_pkg::*;
(
    input  smram_ctrl_t ctrl,
    input  logic        in_smm,
    input  logic        is_code,
    output route_e      route,
    output logic        illegal
);
    always_comb begin
        illegal = ctrl.open_b & ctrl.closed_b;
        route   = ROUTE_BUS;
        if (ctrl.enable_b && !illegal) begin
            if (in_smm) begin
                if (!ctrl.closed_b || is_code) route = ROUTE_DRAM;
            end else if (!ctrl.lock_b && ctrl.open_b) begin
                route = ROUTE_DRAM;
            end
        end
    end
endmodule

// File: rtl/smram_access_router.sv
module smram_access_router
    import smram_pkg::*;
#(
    parameter logic [2:0] SEG_CONST = 3'b010
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       acc_in_smm,
    input  logic       acc_is_code,
    output logic [7:0] ctrl_value,
    output logic       route_dram,
    output logic       illegal_state,
    output logic       smram_enabled
);
    smram_ctrl_t ctrl_q;
    route_e      route;

    smram_ctrl_reg #(.SEG_CONST(SEG_CONST)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q)
    );

    smram_router u_router (
        .ctrl    (ctrl_q),
        .in_smm  (acc_in_smm),
        .is_code (acc_is_code),
        .route   (route),
        .illegal (illegal_state)
    );

    assign ctrl_value    = ctrl_q;
    assign route_dram    = (route == ROUTE_DRAM);
    assign smram_enabled = ctrl_q.enable_b;
endmodule

// File: rtl/smram_access_router_chk.sv
module smram_access_router_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       acc_in_smm,
    input logic       acc_is_code,
    input logic [7:0] ctrl_value,
    input logic       route_dram,
    input logic       illegal_state,
    input logic       smram_enabled
);
    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        ctrl_value[4] |=> ctrl_value[4]);

    a_r3_open_forced_off: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ctrl_value[4]) |=> (!ctrl_value[6] && ctrl_value[4]));

    a_r2_fixed_bits: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctrl_value[7] == 1'b0 && ctrl_value[2:0] == 3'b010));

    a_r4_disabled_bus: assert property (@(posedge clk) disable iff (rst)
        !smram_enabled |-> !route_dram);

    a_r10_illegal_bus: assert property (@(posedge clk) disable iff (rst)
        illegal_state |-> !route_dram);

    a_r8_closed_data_bus: assert property (@(posedge clk) disable iff (rst)
        (acc_in_smm && !acc_is_code && ctrl_value[5]) |-> !route_dram);

    a_r7_smm_open_dram: assert property (@(posedge clk) disable iff (rst)
        (smram_enabled && acc_in_smm && !ctrl_value[5]) |-> route_dram);

    a_r9_locked_outside_bus: assert property (@(posedge clk) disable iff (rst)
        (ctrl_value[4] && !acc_in_smm) |-> !route_dram);

    a_r11_enable_mirror: assert property (@(posedge clk) disable iff (rst)
        smram_enabled == ctrl_value[3]);

    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_value));
endmodule

bind smram_access_router smram_access_router_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .acc_in_smm    (acc_in_smm),
    .acc_is_code   (acc_is_code),
    .ctrl_value    (ctrl_value),
    .route_dram    (route_dram),
    .illegal_state (illegal_state),
    .smram_enabled (smram_enabled)
);

// File: tb/smram_access_router_tb.sv
module smram_access_router_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       acc_in_smm = 1'b0;
    logic       acc_is_code = 1'b0;
    logic [7:0] ctrl_value;
    logic       route_dram;
    logic       illegal_state;
    logic       smram_enabled;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit started  = 0;
    bit done     = 0;
    bit in_reset_cycle = 0;
    bit wrote_last     = 0;
    int model = 8'h02;

    always #5 clk = ~clk;

    smram_access_router u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .acc_in_smm(acc_in_smm), .acc_is_code(acc_is_code),
        .ctrl_value(ctrl_value), .route_dram(route_dram),
        .illegal_state(illegal_state), .smram_enabled(smram_enabled)
    );

    // Behavioural reference register
    always @(posedge clk) begin
        cycles <= cycles + 1;
        started <= 1'b1;
        in_reset_cycle <= rst;
        wrote_last <= wr_en && !rst;
        if (rst) model <= 8'h02;
        else if (wr_en) begin
            int v;
            v = (wr_data & 8'h78) | 8'h02;
            if (model & 8'h10) v = (v & 8'hBF) | 8'h10;
            model <= v;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_route(int m, bit smm, bit code);
        bit en, lk, op, cl;
        en = m[3]; lk = m[4]; op = m[6]; cl = m[5];
        if (!en) return 0;
        if (op && cl) return 0;
        if (smm) return cl ? code : 1'b1;
        if (lk) return 0;
        return op;
    endfunction

    function automatic string route_tag(int m, bit smm);
        if (!m[3]) return "R4";
        if (m[6] && m[5]) return "R10";
        if (smm) return m[5] ? "R8" : "R7";
        if (m[4]) return "R9";
        return m[6] ? "R5" : "R6";
    endfunction

    always @(negedge clk) begin
        if (started && !done) begin
            string rtag;
            rtag = in_reset_cycle ? "R1" : (model[4] ? "R3" : (wrote_last ? "R2" : "R12"));
            check(rtag, ctrl_value, model);
            check(in_reset_cycle ? "R1" : route_tag(model, acc_in_smm),
                  route_dram, exp_route(model, acc_in_smm, acc_is_code));
            check("R10", illegal_state, model[6] & model[5]);
            check("R11", smram_enabled, model[3]);
        end
    end

    task automatic step(bit we, logic [7:0] d, bit smm, bit code);
        @(posedge clk); #2;
        wr_en = we; wr_data = d; acc_in_smm = smm; acc_is_code = code;
    endtask

    task automatic write_and_sweep(logic [7:0] d);
        step(1'b1, d, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) step(1'b0, 8'hA5, k[1], k[0]);
    endtask

    initial begin
        step(1'b0, 8'h00, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b1);
        @(posedge clk); #2; rst = 1'b0;
        for (int k = 0; k < 4; k++) step(1'b0, 8'h00, k[1], k[0]);
        write_and_sweep(8'h08);
        write_and_sweep(8'h48);
        write_and_sweep(8'h28);
        write_and_sweep(8'h68);
        write_and_sweep(8'hFF);
        write_and_sweep(8'h00);
        write_and_sweep(8'h58);
        write_and_sweep(8'h48);
        write_and_sweep(8'h28);
        write_and_sweep(8'h68);
        write_and_sweep(8'h00);
        write_and_sweep(8'h08);
        @(posedge clk); #2; rst = 1'b1;
        step(1'b0, 8'h00, 1'b1, 1'b0);
        @(posedge clk); #2; rst = 1'b0;
        write_and_sweep(8'h48);
        for (int i = 0; i < 300; i++) begin
            int r;
            r = $urandom;
            step(r[0] & r[1], 8'(r >> 8), r[2], r[3]);
            if (i == 150) begin
                @(posedge clk); #2; rst = 1'b1;
                @(posedge clk); #2; rst = 1'b0;
            end
        end
        step(1'b0, 8'h00, 1'b0, 1'b0);
        @(negedge clk); #1;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        done = 1'b1;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule